// File: doc/BRIEF.md
# Sign-Magnitude Phase Error Digitizer

This block turns the timing gap between a reference clock edge and a divided feedback clock edge into a digital phase error, one sample per reference period. A phase/frequency detector holds an "up" flag after a reference rising edge and a "down" flag after a feedback rising edge. When both flags are set, it clears them together. Because the detector reacts to edges and not to levels, it also steers correctly when the two clocks run at different frequencies. This widens the range over which a loop can pull in.

The two flags are OR-ed into a single pulse, and the pulse length is measured by counting cycles of a fast sampling clock. That clock stands in for a fine delay-line quantizer. The count gives an unsigned magnitude. The direction is taken separately: a register samples the up flag at the moment the down flag rises. When the magnitude and the direction are registered, a one-cycle valid strobe marks the sample. The strobe fires when the combined pulse ends, and a digital loop filter consumes the sample on it.

The reference and feedback inputs are sampled in the fast clock domain. One count step equals one fast-clock period. Errors below one step therefore give a magnitude of zero or one, and then only the sign carries information, as in a bang-bang detector.

Top module: `phase_err_digitizer`

## Requirements
- R1: While reset is asserted and after its release, until the first sample, the magnitude is 0, the sign is 0 and valid is low.
- R2: When the edge that arrives second follows the first by d fast-clock cycles, the sample's magnitude equals d, for d up to 2^MAG_W-1.
- R3: The sign is 1 when the reference edge comes first or both edges come in the same cycle. It is 0 when the feedback edge comes first. It equals the up flag as seen at the rising edge of the down flag.
- R4: If the separation exceeds 2^MAG_W-1 cycles, the magnitude is held at 2^MAG_W-1 and does not wrap around.
- R5: Valid is high for exactly one cycle per edge pair. It rises d+2 fast-clock cycles after the cycle in which the first edge was sampled.
- R6: Once the up and down flags are both high, the detector clears both in the next cycle, so the following edge pair is measured from a clean state.
- R7: Edges in the same cycle give magnitude 0; edges one cycle apart give magnitude 1.
- R8: Magnitude and sign change only in the cycle that carries the valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast measuring clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_i | input | 1 | Reference clock, sampled by clk_i |
| fbk_i | input | 1 | Divided feedback clock, sampled by clk_i |
| err_mag_o | output | MAG_W | Unsigned phase error magnitude in clk_i periods |
| err_sign_o | output | 1 | 1 when the reference leads, 0 when the feedback leads |
| err_valid_o | output | 1 | One-cycle strobe for a new sample |

## Verification
The hardest cases to reach are the ones around one quantization step. Edges in the same cycle and edges one cycle apart in either direction are where the sign sampling and the overlap clearing decide the result. The stimulus places each edge on an exact fast-clock negative edge, so the separation is known to the cycle. Directed trials cover separations 0, ±1 and the saturation boundary at 63 and 64. Seeded random separations in both directions then follow.

// File: rtl/phase_err_digitizer.sv
module phase_err_digitizer #(
  parameter int MAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             fbk_i,
  output logic [MAG_W-1:0] err_mag_o,
  output logic             err_sign_o,
  output logic             err_valid_o
);
  localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};

  logic ref_q, fbk_q, up, dn, dn_q, pulse_q, sgn;
  logic [MAG_W-1:0] cnt;

  wire ref_rise = ref_i & ~ref_q;
  wire fbk_rise = fbk_i & ~fbk_q;
  wire clr      = up & dn;
  wire pulse    = up | dn;
  wire fall     = pulse_q & ~pulse;
  wire dn_rise  = dn & ~dn_q;
  wire single   = up ^ dn;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      fbk_q <= 1'b0;
      up    <= 1'b0;
      dn    <= 1'b0;
    end else begin
      ref_q <= ref_i;
      fbk_q <= fbk_i;
      up    <= clr ? 1'b0 : (up | ref_rise);
      dn    <= clr ? 1'b0 : (dn | fbk_rise);
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      dn_q    <= 1'b0;
      pulse_q <= 1'b0;
      sgn     <= 1'b0;
      cnt     <= '0;
    end else begin
      dn_q    <= dn;
      pulse_q <= pulse;
      if (dn_rise) sgn <= up;
      if (fall) cnt <= '0;
      else if (single && cnt != MAG_MAX) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      err_mag_o   <= '0;
      err_sign_o  <= 1'b0;
      err_valid_o <= 1'b0;
    end else begin
      err_valid_o <= fall;
      if (fall) begin
        err_mag_o  <= cnt;
        err_sign_o <= sgn;
      end
    end
  end
endmodule

module phase_err_digitizer_chk #(
  parameter int MAG_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             up,
  input logic             dn,
  input logic [MAG_W-1:0] cnt,
  input logic             pulse_q,
  input logic [MAG_W-1:0] err_mag_o,
  input logic             err_sign_o,
  input logic             err_valid_o
);
  localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};

  // R6
  pfd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up && dn) |=> (!up && !dn));

  // R5
  strobe_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |=> !err_valid_o);

  // R4
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == MAG_MAX && (up || dn)) |=> (cnt == MAG_MAX));

  // R8
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_valid_o |-> ($stable(err_mag_o) && $stable(err_sign_o)));

  // R2
  fresh_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((up || dn) && !pulse_q) |-> (cnt == '0));
endmodule

bind phase_err_digitizer phase_err_digitizer_chk #(.MAG_W(MAG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .up(up), .dn(dn), .cnt(cnt),
  .pulse_q(pulse_q), .err_mag_o(err_mag_o), .err_sign_o(err_sign_o),
  .err_valid_o(err_valid_o)
);

// File: tb/test_phase_err_digitizer.sv
module test_phase_err_digitizer;
  localparam int MAG_W = 6;
  localparam int MAXV  = (1 << MAG_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, ref_s = 1'b0, fbk_s = 1'b0;
  logic [MAG_W-1:0] mag;
  logic sgn, vld;
  int cyc = 0, checks = 0, fails = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phase_err_digitizer #(.MAG_W(MAG_W)) i_phase_err_digitizer (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .fbk_i(fbk_s),
    .err_mag_o(mag), .err_sign_o(sgn), .err_valid_o(vld));

  function automatic int exp_mag(input int d);
    int a = (d < 0) ? -d : d;
    return (a > MAXV) ? MAXV : a;
  endfunction

  function automatic bit exp_sign(input int d);
    return d >= 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic trial(input int d);
    int a = (d < 0) ? -d : d;
    int t0;
    bit seen = 0;
    @(negedge clk);
    ref_s = 0; fbk_s = 0;
    repeat (4) @(negedge clk);
    if (d >= 0) ref_s = 1; else fbk_s = 1;
    t0 = cyc;
    if (a == 0) fbk_s = 1;
    else begin
      repeat (a) @(negedge clk);
      ref_s = 1; fbk_s = 1;
    end
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (vld) begin seen = 1; break; end
    end
    chk("R5 strobe seen", int'(seen), 1);
    chk("R5 latency", cyc - t0, a + 3);
    chk((a > MAXV) ? "R4 saturated magnitude" : "R2 magnitude", int'(mag), exp_mag(d));
    chk("R3 sign", int'(sgn), int'(exp_sign(d)));
    @(negedge clk);
    chk("R5 one-cycle strobe", int'(vld), 0);
    chk("R8 hold after strobe", int'(mag), exp_mag(d));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 reset magnitude", int'(mag), 0);
    chk("R1 reset sign", int'(sgn), 0);
    chk("R1 reset valid", int'(vld), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle valid", int'(vld), 0);
    trial(0);   // R7 coincident edges
    chk("R7 coincident magnitude", int'(mag), 0);
    trial(1);   // R7 one step, reference first
    trial(-1);  // R7 one step, feedback first
    chk("R7 one-step magnitude", int'(mag), 1);
    trial(5);
    trial(-5);  // R6 back-to-back pairs measured cleanly
    trial(63);
    trial(64);
    trial(-100);
    for (int i = 0; i < 30; i++) trial(int'($urandom_range(0, 180)) - 90);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule